// File: doc/BRIEF.md
# Double-Buffered Info Packet Store

This block holds the generic data-island packets that a display transmitter inserts into blanking intervals. There are fifteen packet slots. Each slot is nine 32-bit words long: a header word carrying four header bytes, followed by eight payload words. Software reaches the store through a small register port. It loads a flat word index, which is the slot number times nine, and then streams the nine words of the slot through one data register. The index moves forward by one on every write.

Each slot keeps two copies of its words. Software writes only the staging copy. The transmitter reads only the active copy. A slot's staging words reach its active copy only when software arms a commit for that slot, and it can arm one of two kinds. An immediate commit takes effect on the next block-update pulse that arrives while the block-update lock input is low. A frame commit takes effect on the next frame-start pulse. The armed bits clear themselves once the copy is made, so reading them back shows which commits are still pending.

The transmitter fetches words through a registered read port. A sticky conflict flag is set when that port reads in the same cycle that software writes the data register. Software clears the flag by writing a one to a clear bit.

Top module: `info_pkt_store`

## Requirements
- R1: After reset, every register reads zero, `tx_rdata` is zero, and every staging word and active word is zero.
- R2: The register map is as follows. `reg_addr` 0 is the word index (bits 7:0). Address 1 is the data register, which reads zero. Address 2 holds the immediate-commit bits and address 3 the frame-commit bits, with bit s belonging to slot s. Address 4 is status: bit 0 is the conflict flag, and writing 1 to bit 1 clears it. Word 0 of a slot holds header byte k in bits 8k+7:8k.
- R3: A write to the data register while the index is below 135 stores the word at slot index/9, word index%9 of the staging copy, and then increments the index by one.
- R4: A write to the data register while the index is 135 or above changes no storage and leaves the index unchanged.
- R5: Staging words are not visible on the transmitter port until the slot is committed.
- R6: An armed immediate-commit bit copies the slot's nine staging words to its active copy on a `blk_update` pulse when `blk_lock` is low. While `blk_lock` is high, `blk_update` commits nothing.
- R7: An armed frame-commit bit copies the slot on a `frame_start` pulse, and `blk_update` has no effect on it.
- R8: Writing a commit register ORs ones into the pending bits. Each pending bit reads back as 1 until its commit happens, then returns to 0. Slots that are not armed are not copied.
- R9: A transmitter read with `tx_rd` high returns the active word in `tx_rdata` one cycle later. A slot of 15 or more, or a word of 9 or more, returns zero. `tx_rdata` holds its value while `tx_rd` is low.
- R10: A data-register write in a cycle where `tx_rd` is high sets the conflict flag from the next cycle on. The flag stays set until status bit 1 is written with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| blk_update | input | 1 | Block-update event pulse |
| blk_lock | input | 1 | Block-update lock; high holds off immediate commits |
| frame_start | input | 1 | Frame-start pulse |
| tx_rd | input | 1 | Transmitter read request |
| tx_slot | input | 4 | Transmitter slot number |
| tx_word | input | 4 | Transmitter word number in the slot |
| tx_rdata | output | 32 | Active word, registered |

## Verification
Register writes, commit pulses and conflicts all update state at the edge that samples them. The index, the pending bits and the conflict flag therefore show on `reg_rdata` right after that edge. A commit becomes visible on `tx_rdata` only after a transmitter read issued in a later cycle, which adds one more edge. The bench drives inputs at the falling edge. A behavioural model advances on the same inputs, and outputs are compared at the next falling edge. Each check therefore samples exactly one rising edge after its stimulus, and read-after-commit checks are issued as a separate read cycle.

// File: rtl/info_pkt_pkg.sv
package info_pkt_pkg;
  localparam int NUM_SLOTS_DEF = 15;
  localparam int WPS_DEF       = 9;
  localparam int DW_DEF        = 32;

  typedef enum logic [2:0] {
    REG_INDEX  = 3'd0,
    REG_DATA   = 3'd1,
    REG_IMM    = 3'd2,
    REG_FRM    = 3'd3,
    REG_STATUS = 3'd4
  } reg_sel_e;

  function automatic int slot_of(int idx, int wps);
    return idx / wps;
  endfunction

  function automatic int word_of(int idx, int wps);
    return idx % wps;
  endfunction

  function automatic logic in_range(int idx, int total);
    return idx < total;
  endfunction
endpackage

// File: rtl/info_pkt_ctrl.sv
module info_pkt_ctrl
  import info_pkt_pkg::*;
#(
  parameter int NUM_SLOTS = 15,
  parameter int WPS       = 9,
  parameter int DW        = 32,
  parameter int IDX_W     = 8,
  parameter int SLOT_W    = 4,
  parameter int WORD_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_addr,
  input  logic [IDX_W-1:0]     idx_wdata,
  input  logic [NUM_SLOTS-1:0] sel_wdata,
  input  logic                 clr_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic                 blk_update,
  input  logic                 blk_lock,
  input  logic                 frame_start,
  input  logic                 tx_rd,
  output logic                 data_wr,
  output logic                 data_acc,
  output logic [SLOT_W-1:0]    wr_slot,
  output logic [WORD_W-1:0]    wr_word,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_SLOTS-1:0] imm_pend,
  output logic [NUM_SLOTS-1:0] frm_pend,
  output logic [NUM_SLOTS-1:0] commit,
  output logic                 conflict,
  output logic                 imm_wr,
  output logic                 frm_wr
);
  localparam int TOTAL = NUM_SLOTS * WPS;

  logic                 idx_wr, stat_wr;
  logic [NUM_SLOTS-1:0] imm_fire, frm_fire;

  always_comb begin
    data_wr  = reg_wr && (reg_addr == REG_DATA);
    idx_wr   = reg_wr && (reg_addr == REG_INDEX);
    imm_wr   = reg_wr && (reg_addr == REG_IMM);
    frm_wr   = reg_wr && (reg_addr == REG_FRM);
    stat_wr  = reg_wr && (reg_addr == REG_STATUS);
    data_acc = data_wr && in_range(int'(idx), TOTAL);
    wr_slot  = SLOT_W'(slot_of(int'(idx), WPS));
    wr_word  = WORD_W'(word_of(int'(idx), WPS));
    imm_fire = (blk_update && !blk_lock) ? imm_pend : '0;
    frm_fire = frame_start ? frm_pend : '0;
    commit   = imm_fire | frm_fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      imm_pend <= '0;
      frm_pend <= '0;
      conflict <= 1'b0;
    end else begin
      if (idx_wr)        idx <= idx_wdata;
      else if (data_acc) idx <= idx + IDX_W'(1);
      imm_pend <= (imm_pend & ~imm_fire) | (imm_wr ? sel_wdata : '0);
      frm_pend <= (frm_pend & ~frm_fire) | (frm_wr ? sel_wdata : '0);
      if (data_wr && tx_rd)         conflict <= 1'b1;
      else if (stat_wr && clr_wdata) conflict <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_INDEX:  reg_rdata[IDX_W-1:0]     = idx;
      REG_IMM:    reg_rdata[NUM_SLOTS-1:0] = imm_pend;
      REG_FRM:    reg_rdata[NUM_SLOTS-1:0] = frm_pend;
      REG_STATUS: reg_rdata[0]             = conflict;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/info_pkt_slot.sv
module info_pkt_slot #(
  parameter int WPS    = 9,
  parameter int DW     = 32,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DW-1:0]     wdata,
  input  logic              commit,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] stg [WPS];
  logic [DW-1:0] act [WPS];

  for (genvar w = 0; w < WPS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg[w] <= '0;
        act[w] <= '0;
      end else begin
        if (commit) act[w] <= stg[w];
        if (wr_en && wr_word == WORD_W'(w)) stg[w] <= wdata;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WPS; w++)
      if (rd_word == WORD_W'(w)) rd_data = act[w];
  end
endmodule

// File: rtl/info_pkt_txport.sv
module info_pkt_txport #(
  parameter int NUM_SLOTS = 15,
  parameter int DW        = 32,
  parameter int SLOT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_rd,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [DW-1:0]     slot_rd [NUM_SLOTS],
  output logic [DW-1:0]     tx_rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (tx_slot == SLOT_W'(s)) sel = slot_rd[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     tx_rdata <= '0;
    else if (tx_rd) tx_rdata <= sel;
  end
endmodule

// File: rtl/info_pkt_store.sv
module info_pkt_store
  import info_pkt_pkg::*;
#(
  parameter int NUM_SLOTS = NUM_SLOTS_DEF,
  parameter int WPS       = WPS_DEF,
  parameter int DW        = DW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          blk_update,
  input  logic          blk_lock,
  input  logic          frame_start,
  input  logic          tx_rd,
  input  logic [3:0]    tx_slot,
  input  logic [3:0]    tx_word,
  output logic [DW-1:0] tx_rdata
);
  localparam int IDX_W  = $clog2(NUM_SLOTS * WPS + 1);
  localparam int SLOT_W = 4;
  localparam int WORD_W = 4;

  logic                 data_wr, data_acc, conflict, imm_wr, frm_wr;
  logic [SLOT_W-1:0]    wr_slot;
  logic [WORD_W-1:0]    wr_word;
  logic [IDX_W-1:0]     idx;
  logic [NUM_SLOTS-1:0] imm_pend, frm_pend, commit;
  logic [DW-1:0]        slot_rd [NUM_SLOTS];

  info_pkt_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .WPS(WPS), .DW(DW),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .idx_wdata(reg_wdata[IDX_W-1:0]), .sel_wdata(reg_wdata[NUM_SLOTS-1:0]),
    .clr_wdata(reg_wdata[1]), .reg_rdata(reg_rdata),
    .blk_update(blk_update), .blk_lock(blk_lock), .frame_start(frame_start),
    .tx_rd(tx_rd), .data_wr(data_wr), .data_acc(data_acc),
    .wr_slot(wr_slot), .wr_word(wr_word), .idx(idx),
    .imm_pend(imm_pend), .frm_pend(frm_pend), .commit(commit),
    .conflict(conflict), .imm_wr(imm_wr), .frm_wr(frm_wr)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    info_pkt_slot #(.WPS(WPS), .DW(DW), .WORD_W(WORD_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(data_acc && wr_slot == SLOT_W'(s)),
      .wr_word(wr_word), .wdata(reg_wdata),
      .commit(commit[s]), .rd_word(tx_word), .rd_data(slot_rd[s])
    );
  end

  info_pkt_txport #(.NUM_SLOTS(NUM_SLOTS), .DW(DW), .SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_rd(tx_rd), .tx_slot(tx_slot),
    .slot_rd(slot_rd), .tx_rdata(tx_rdata)
  );
endmodule

// File: rtl/info_pkt_store_chk.sv
module info_pkt_store_chk #(
  parameter int NUM_SLOTS = 15,
  parameter int DW        = 32,
  parameter int IDX_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 data_wr,
  input logic                 data_acc,
  input logic [IDX_W-1:0]     idx,
  input logic                 tx_rd,
  input logic                 conflict,
  input logic                 blk_update,
  input logic                 blk_lock,
  input logic                 frame_start,
  input logic                 imm_wr,
  input logic                 frm_wr,
  input logic [NUM_SLOTS-1:0] imm_pend,
  input logic [NUM_SLOTS-1:0] frm_pend,
  input logic [NUM_SLOTS-1:0] commit,
  input logic [DW-1:0]        tx_rdata
);
  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> idx == $past(idx) + IDX_W'(1));

  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !data_acc) |=> $stable(idx));

  assert_lock_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_lock && !frame_start) |-> commit == '0);

  assert_frame_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !frm_wr) |=> frm_pend == '0);

  assert_imm_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_update && !blk_lock && !imm_wr) |=> imm_pend == '0);

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_rd |=> $stable(tx_rdata));

  assert_conflict_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rd && data_wr) |=> conflict);
endmodule

bind info_pkt_store info_pkt_store_chk #(
  .NUM_SLOTS(NUM_SLOTS), .DW(DW), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_acc(data_acc),
  .idx(idx), .tx_rd(tx_rd), .conflict(conflict), .blk_update(blk_update),
  .blk_lock(blk_lock), .frame_start(frame_start), .imm_wr(imm_wr),
  .frm_wr(frm_wr), .imm_pend(imm_pend), .frm_pend(frm_pend),
  .commit(commit), .tx_rdata(tx_rdata)
);

// File: tb/info_pkt_store_bench.sv
`timescale 1ns/1ps
module info_pkt_store_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        blk_update = 1'b0, blk_lock = 1'b0, frame_start = 1'b0, tx_rd = 1'b0;
  logic [3:0]  tx_slot = '0, tx_word = '0;
  logic [31:0] tx_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // behavioural reference: flat word arrays
  logic [31:0] m_stg [135];
  logic [31:0] m_act [135];
  int          m_idx = 0;
  logic [14:0] m_imm = '0, m_frm = '0;
  logic        m_conf = 1'b0;
  logic [31:0] m_tx = '0;

  always #4 clk = ~clk;

  info_pkt_store u_info_pkt_store (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_update(blk_update),
    .blk_lock(blk_lock), .frame_start(frame_start), .tx_rd(tx_rd),
    .tx_slot(tx_slot), .tx_word(tx_word), .tx_rdata(tx_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return 32'(m_idx);
      3'd2: return {17'd0, m_imm};
      3'd3: return {17'd0, m_frm};
      3'd4: return {31'd0, m_conf};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd2, 3'd3: return "R8";
      3'd4: return "R10";
      default: return "R2";
    endcase
  endfunction

  // advance the model on current inputs, clock once, compare both outputs
  task automatic step();
    if (tx_rd)
      m_tx = (tx_slot < 15 && tx_word < 9) ? m_act[int'(tx_slot) * 9 + int'(tx_word)] : 32'd0;
    for (int s = 0; s < 15; s++)
      if ((m_imm[s] && blk_update && !blk_lock) || (m_frm[s] && frame_start))
        for (int w = 0; w < 9; w++) m_act[s * 9 + w] = m_stg[s * 9 + w];
    if (blk_update && !blk_lock) m_imm = '0;
    if (frame_start) m_frm = '0;
    if (reg_wr) begin
      case (reg_addr)
        3'd0: m_idx = int'(reg_wdata[7:0]);
        3'd1: begin
          if (tx_rd) m_conf = 1'b1;
          if (m_idx < 135) begin m_stg[m_idx] = reg_wdata; m_idx++; end
        end
        3'd2: m_imm = m_imm | reg_wdata[14:0];
        3'd3: m_frm = m_frm | reg_wdata[14:0];
        3'd4: if (reg_wdata[1]) m_conf = 1'b0;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(tx_rdata === m_tx, "R9 model tx", tx_rdata, m_tx);
    check(reg_rdata === m_read(reg_addr), addr_tag(reg_addr), reg_rdata, m_read(reg_addr));
  endtask

  task automatic quiet();
    reg_wr = 0; blk_update = 0; frame_start = 0; tx_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    quiet(); reg_wr = 1; reg_addr = a; reg_wdata = d; step(); quiet();
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    quiet(); reg_addr = a; step();
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic txr(input int s, input int w, input logic [31:0] exp, input string tag);
    quiet(); tx_rd = 1; tx_slot = 4'(s); tx_word = 4'(w); step(); quiet();
    check(tx_rdata === exp, tag, tx_rdata, exp);
  endtask

  task automatic pulse(input bit blk, input bit lock, input bit frm);
    quiet(); blk_update = blk; blk_lock = lock; frame_start = frm; step(); quiet(); blk_lock = 0;
  endtask

  initial begin
    for (int i = 0; i < 135; i++) begin m_stg[i] = '0; m_act[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    rd(3'd0, 0, "R1 index"); rd(3'd2, 0, "R1 imm"); rd(3'd3, 0, "R1 frm");
    rd(3'd4, 0, "R1 status"); txr(0, 0, 0, "R1 active");
    // R3: slot 2 load
    wr(3'd0, 32'd18);
    wr(3'd1, 32'h44332211);
    for (int k = 1; k < 9; k++) wr(3'd1, 32'hA000_0000 + 32'(k));
    rd(3'd0, 32'd27, "R3 index advanced");
    txr(2, 0, 0, "R5 staging hidden");
    // R6 / R8 immediate commit
    wr(3'd2, 32'h4);
    rd(3'd2, 32'h4, "R8 pending");
    pulse(1, 1, 0);
    rd(3'd2, 32'h4, "R6 locked stays pending");
    txr(2, 0, 0, "R6 locked no copy");
    pulse(1, 0, 0);
    rd(3'd2, 0, "R8 self-clear");
    txr(2, 0, 32'h44332211, "R2 header word");
    txr(2, 8, 32'hA000_0008, "R6 payload copied");
    txr(3, 0, 0, "R8 unarmed slot");
    // R4 / R7 slot 14 and end of store
    wr(3'd0, 32'd126);
    for (int k = 0; k < 9; k++) wr(3'd1, 32'hB000_0000 + 32'(k));
    rd(3'd0, 32'd135, "R4 index at end");
    wr(3'd1, 32'hDEAD_BEEF);
    rd(3'd0, 32'd135, "R4 index held");
    wr(3'd3, 32'h4000);
    pulse(1, 0, 0);
    rd(3'd3, 32'h4000, "R7 blk_update ignored");
    txr(14, 0, 0, "R7 no copy yet");
    pulse(0, 0, 1);
    rd(3'd3, 0, "R7 self-clear");
    txr(14, 8, 32'hB000_0008, "R4 last word not overwritten");
    txr(14, 0, 32'hB000_0000, "R7 frame copy");
    // R9 out-of-range and hold
    txr(15, 0, 0, "R9 slot range");
    txr(2, 9, 0, "R9 word range");
    txr(2, 1, 32'hA000_0001, "R9 read");
    quiet(); step(); step();
    check(tx_rdata === 32'hA000_0001, "R9 hold", tx_rdata, 32'hA000_0001);
    wr(3'd0, 32'd200);
    wr(3'd1, 32'h1234_5678);
    rd(3'd0, 32'd200, "R4 high index ignored");
    // R10 conflict
    wr(3'd0, 32'd0);
    quiet(); reg_wr = 1; reg_addr = 3'd1; reg_wdata = 32'h5555_0000; tx_rd = 1; tx_slot = 0; tx_word = 0;
    step(); quiet();
    rd(3'd4, 32'd1, "R10 set");
    step();
    rd(3'd4, 32'd1, "R10 sticky");
    wr(3'd4, 32'd1);
    rd(3'd4, 32'd1, "R10 bit0 write no clear");
    wr(3'd4, 32'd2);
    rd(3'd4, 32'd0, "R10 cleared");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule